// File: doc/BRIEF.md
# Trace flush and trigger controller

This block is the control core of a trace-port formatter. It holds one control register, reached over a plain read/write register bus. It watches a trigger pin, a flush pin, a trigger down-counter and the flush handshake toward the trace source, and from them it produces four things: flush requests, one-cycle trigger indications, stop commands for the formatter, and a request to the packer to insert a flush-completion marker packet.

Only one flush can be in flight at a time. A flush is raised on `fl_valid` and held until `fl_ready` answers. Flush requests can come from three places: a self-clearing manual bit, the flush pin and trigger events. A request that arrives while a flush is already pending is merged into it. A stop is not immediate. The block first asks the packer to drain any partial packet, and it sets its stopped status only after the packer acknowledges the drain. The two formatting mode bits can change only while the block is stopped.

Top module: `tflush_ctrl`

## Requirements
- R1: After reset, reading address 0x304 returns 0x00001000, reading any other address returns 0, `stopped` is 1, and `fl_valid`, `trig_ind`, `mark_req` and `stop_req` are all 0.
- R2: Control-register bits 31:16, 14, 11, 7, 3 and 2 always read 0, and writes to them are ignored. The writable mask is 0x0000B773.
- R3: Writing the control register with bit 6 set raises `fl_valid` on the next cycle. Bit 6 then reads 1 until the cycle after `fl_valid && fl_ready`, when it reads 0. Writing 0 to bit 6 has no effect.
- R4: With bit 4 set, a rising edge on `flush_in` raises a flush request. With bit 4 clear, the edge has no effect.
- R5: A trigger event is either a cycle with `tc_hit` high, or a rising edge of `trig_in` while `tc_reload_zero` is high. With bit 5 set, a trigger event raises a flush request.
- R6: At most one flush is outstanding. `fl_valid` stays high until a cycle with `fl_ready` high and falls on the next cycle. A request from any source that arrives while `fl_valid` is high, including in the completion cycle, is absorbed into the pending flush.
- R7: `trig_ind` is a one-cycle pulse, given in the cycle after any of these causes: a `trig_in` rising edge with bit 8 set, a trigger event with bit 9 set, or a flush completion with bit 10 set.
- R8: With bit 12 set and the block running, a flush completion raises `stop_req` on the next cycle. `stop_req` holds until `drain_done`, and on the next cycle `stop_req` falls and `stopped` rises.
- R9: With bit 13 set and the block running, a trigger event raises `stop_req` in the same way as R8. While `stopped` is high, stop causes are ignored.
- R10: With bit 15 set and at least one of bits 0 and 1 set, a flush completion gives a one-cycle `mark_req` on the next cycle, with `mark_id` = 0x7B and `mark_byte` = 0x00. In bypass mode (bits 1:0 both 0), bit 15 has no effect.
- R11: Bits 0 (`fmt_en`) and 1 (`fmt_cont`) take the written value only while `stopped` is high. At other times they keep their value, and the rest of the same write still takes effect.
- R12: A register write made while `stopped` is high, with no stop pending and with bit 0 or bit 1 written as 1, clears `stopped` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| trig_in | input | 1 | Trigger pin, level, rising edge used |
| flush_in | input | 1 | Flush pin, level, rising edge used |
| tc_hit | input | 1 | Trigger counter reached zero while counting down |
| tc_reload_zero | input | 1 | Trigger counter reload value is zero |
| fl_valid | output | 1 | Flush request toward the trace source |
| fl_ready | input | 1 | Flush completion response |
| trig_ind | output | 1 | Trigger indication pulse |
| stop_req | output | 1 | Drain-and-stop command to the packer |
| drain_done | input | 1 | Packer drain acknowledge |
| stopped | output | 1 | Formatter stopped status |
| mark_req | output | 1 | Insert flush-completion marker packet |
| mark_id | output | 8 | Marker packet ID |
| mark_byte | output | 8 | Marker packet payload byte |
| fmt_en | output | 1 | Formatter enable mode bit |
| fmt_cont | output | 1 | Continuous formatting mode bit |

## Verification
The collision of interest is a flush completion that lands in the same cycle as a trigger event or a new flush request. One edge then has to complete the pending flush, drop the newly arrived request, clear the manual bit, and start both the trigger indication and a stop. The bench provokes this in directed steps: it holds `fl_ready` high while it writes bit 6, pulses `tc_hit` and raises `flush_in`. Long random runs then overlap these inputs at high rates. A cycle model written from the requirements judges every output on every cycle, so a request that is wrongly kept after completion shows up as an extra `fl_valid` cycle. A manual bit that never clears shows up in the read data.

// File: rtl/tflush_pkg.sv
package tflush_pkg;

    localparam int CTRL_W = 16;
    localparam logic [11:0] CTRL_ADDR = 12'h304;
    localparam logic [CTRL_W-1:0] CTRL_RST = 16'h1000;
    localparam logic [CTRL_W-1:0] WMASK = 16'hB773;
    localparam int MAN_BIT = 6;
    localparam logic [7:0] MARK_ID = 8'h7B;
    localparam logic [7:0] MARK_BYTE = 8'h00;

    // Control register layout, bit 15 down to bit 0
    typedef struct packed {
        logic       embed;      // 15 marker after flush
        logic       rsv14;
        logic       stop_trg;   // 13 stop on trigger event
        logic       stop_fl;    // 12 stop on flush completion
        logic       rsv11;
        logic       ind_fl;     // 10 indicate on flush completion
        logic       ind_evt;    // 9  indicate on trigger event
        logic       ind_pin;    // 8  indicate on trigger pin
        logic       rsv7;
        logic       man;        // 6  manual flush, self clearing
        logic       fl_trg;     // 5  flush on trigger event
        logic       fl_pin;     // 4  flush on flush pin
        logic [1:0] rsv3_2;
        logic       cont;       // 1  continuous mode
        logic       en;         // 0  formatter enable
    } ctrl_t;

    function automatic logic fmt_active(input ctrl_t c);
        return c.en | c.cont;
    endfunction

endpackage

// File: rtl/tflush_edge.sv
module tflush_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= sig;
    end

    assign rise = sig & ~q;
endmodule

// File: rtl/tflush_regs.sv
module tflush_regs
    import tflush_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ok,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              stopped,
    input  logic              fl_done,
    output ctrl_t             ctrl,
    output logic              man_set
);
    ctrl_t nxt;

    always_comb begin
        nxt = ctrl;
        if (wr_ok) begin
            nxt = ctrl_t'(wdata & WMASK);
            nxt.man = ctrl.man | wdata[MAN_BIT];
            if (!stopped) begin
                nxt.en   = ctrl.en;
                nxt.cont = ctrl.cont;
            end
        end
        if (fl_done) nxt.man = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl <= ctrl_t'(CTRL_RST);
        else     ctrl <= nxt;
    end

    assign man_set = wr_ok & wdata[MAN_BIT];
endmodule

// File: rtl/tflush_flush.sv
module tflush_flush (
    input  logic clk,
    input  logic rst,
    input  logic man_set,
    input  logic fl_trg_en,
    input  logic fl_pin_en,
    input  logic ind_pin_en,
    input  logic ind_evt_en,
    input  logic ind_fl_en,
    input  logic mark_en,
    input  logic trg_evt,
    input  logic trig_rise,
    input  logic flush_rise,
    input  logic fl_ready,
    output logic fl_valid,
    output logic fl_done,
    output logic trig_ind,
    output logic mark_req
);
    logic new_req;

    assign fl_done = fl_valid & fl_ready;
    assign new_req = man_set | (fl_trg_en & trg_evt) | (fl_pin_en & flush_rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_valid <= 1'b0;
            trig_ind <= 1'b0;
            mark_req <= 1'b0;
        end else begin
            // pending flush absorbs any new request until it completes
            fl_valid <= fl_valid ? ~fl_ready : new_req;
            trig_ind <= (ind_pin_en & trig_rise) | (ind_evt_en & trg_evt)
                      | (ind_fl_en & fl_done);
            mark_req <= mark_en & fl_done;
        end
    end
endmodule

// File: rtl/tflush_stop.sv
module tflush_stop (
    input  logic clk,
    input  logic rst,
    input  logic stop_fl_en,
    input  logic stop_trg_en,
    input  logic fl_done,
    input  logic trg_evt,
    input  logic drain_done,
    input  logic mode_wr,
    output logic stop_req,
    output logic stopped
);
    logic cause;

    assign cause = (stop_fl_en & fl_done) | (stop_trg_en & trg_evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_req <= 1'b0;
            stopped  <= 1'b1;
        end else if (stop_req && drain_done) begin
            stop_req <= 1'b0;
            stopped  <= 1'b1;
        end else if (!stopped && cause) begin
            stop_req <= 1'b1;
        end else if (stopped && !stop_req && mode_wr) begin
            stopped  <= 1'b0;
        end
    end
endmodule

// File: rtl/tflush_ctrl.sv
module tflush_ctrl
    import tflush_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              trig_in,
    input  logic              flush_in,
    input  logic              tc_hit,
    input  logic              tc_reload_zero,
    output logic              fl_valid,
    input  logic              fl_ready,
    output logic              trig_ind,
    output logic              stop_req,
    input  logic              drain_done,
    output logic              stopped,
    output logic              mark_req,
    output logic [7:0]        mark_id,
    output logic [7:0]        mark_byte,
    output logic              fmt_en,
    output logic              fmt_cont
);
    localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(CTRL_ADDR);

    ctrl_t       ctrl;
    logic        hit_ctrl;
    logic        wr_ok;
    logic        man_set;
    logic        fl_done;
    logic        trg_evt;
    logic [1:0]  rise;
    logic        unused_hi;

    assign unused_hi = ^reg_wdata[DATA_W-1:CTRL_W];
    assign hit_ctrl  = (reg_addr == CTRL_OFS);
    assign wr_ok     = reg_wr & hit_ctrl;
    assign trg_evt   = tc_hit | (tc_reload_zero & rise[0]);

    tflush_edge #(.W(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  ({flush_in, trig_in}),
        .rise (rise)
    );

    tflush_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_ok   (wr_ok),
        .wdata   (reg_wdata[CTRL_W-1:0]),
        .stopped (stopped),
        .fl_done (fl_done),
        .ctrl    (ctrl),
        .man_set (man_set)
    );

    tflush_flush u_flush (
        .clk        (clk),
        .rst        (rst),
        .man_set    (man_set),
        .fl_trg_en  (ctrl.fl_trg),
        .fl_pin_en  (ctrl.fl_pin),
        .ind_pin_en (ctrl.ind_pin),
        .ind_evt_en (ctrl.ind_evt),
        .ind_fl_en  (ctrl.ind_fl),
        .mark_en    (ctrl.embed & fmt_active(ctrl)),
        .trg_evt    (trg_evt),
        .trig_rise  (rise[0]),
        .flush_rise (rise[1]),
        .fl_ready   (fl_ready),
        .fl_valid   (fl_valid),
        .fl_done    (fl_done),
        .trig_ind   (trig_ind),
        .mark_req   (mark_req)
    );

    tflush_stop u_stop (
        .clk         (clk),
        .rst         (rst),
        .stop_fl_en  (ctrl.stop_fl),
        .stop_trg_en (ctrl.stop_trg),
        .fl_done     (fl_done),
        .trg_evt     (trg_evt),
        .drain_done  (drain_done),
        .mode_wr     (wr_ok & (reg_wdata[0] | reg_wdata[1])),
        .stop_req    (stop_req),
        .stopped     (stopped)
    );

    assign reg_rdata = hit_ctrl ? DATA_W'(ctrl) : '0;
    assign mark_id   = MARK_ID;
    assign mark_byte = MARK_BYTE;
    assign fmt_en    = ctrl.en;
    assign fmt_cont  = ctrl.cont;
endmodule

// File: rtl/tflush_chk.sv
module tflush_chk (
    input logic clk,
    input logic rst,
    input logic trig_in,
    input logic tc_hit,
    input logic fl_valid,
    input logic fl_ready,
    input logic trig_ind,
    input logic mark_req,
    input logic stop_req,
    input logic drain_done,
    input logic stopped,
    input logic fmt_en,
    input logic fmt_cont
);
    p_valid_hold_r6: assert property (@(posedge clk) disable iff (rst)
        fl_valid && !fl_ready |=> fl_valid);

    p_valid_drop_r3: assert property (@(posedge clk) disable iff (rst)
        fl_valid && fl_ready |=> !fl_valid);

    p_trig_cause_r7: assert property (@(posedge clk) disable iff (rst)
        trig_ind |-> ($past(trig_in) || $past(tc_hit) || $past(fl_valid && fl_ready)));

    p_mark_after_done_r10: assert property (@(posedge clk) disable iff (rst)
        mark_req |-> $past(fl_valid && fl_ready));

    p_stop_hold_r8: assert property (@(posedge clk) disable iff (rst)
        stop_req && !drain_done |=> stop_req);

    p_stop_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(stopped) |-> $past(stop_req && drain_done));

    p_mode_lock_r11: assert property (@(posedge clk) disable iff (rst)
        !stopped |=> $stable({fmt_cont, fmt_en}));

    p_no_stop_when_stopped_r9: assert property (@(posedge clk) disable iff (rst)
        stopped |-> !stop_req);
endmodule

bind tflush_ctrl tflush_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .trig_in    (trig_in),
    .tc_hit     (tc_hit),
    .fl_valid   (fl_valid),
    .fl_ready   (fl_ready),
    .trig_ind   (trig_ind),
    .mark_req   (mark_req),
    .stop_req   (stop_req),
    .drain_done (drain_done),
    .stopped    (stopped),
    .fmt_en     (fmt_en),
    .fmt_cont   (fmt_cont)
);

// File: tb/sim_tflush_ctrl.sv
module sim_tflush_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = 12'h304;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        trig_in = 1'b0, flush_in = 1'b0, tc_hit = 1'b0, tc_reload_zero = 1'b0;
    logic        fl_valid, fl_ready = 1'b0, trig_ind, stop_req, drain_done = 1'b0;
    logic        stopped, mark_req, fmt_en, fmt_cont;
    logic [7:0]  mark_id, mark_byte;

    int tests = 0;
    int fails = 0;

    // reference state built from the requirements
    logic [15:0] m_ctrl;
    logic m_valid, m_pend, m_stopped, m_ti, m_mk, m_tq, m_fq;

    always #5 clk = ~clk;

    tflush_ctrl u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
        .flush_in(flush_in), .tc_hit(tc_hit), .tc_reload_zero(tc_reload_zero),
        .fl_valid(fl_valid), .fl_ready(fl_ready), .trig_ind(trig_ind),
        .stop_req(stop_req), .drain_done(drain_done), .stopped(stopped),
        .mark_req(mark_req), .mark_id(mark_id), .mark_byte(mark_byte),
        .fmt_en(fmt_en), .fmt_cont(fmt_cont)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input logic [11:0] a);
        return (a == 12'h304) ? {16'h0, m_ctrl} : 32'h0;
    endfunction

    task automatic compare_all();
        check("R2/R3/R11 rdata", reg_rdata, exp_rdata(reg_addr));
        check("R3/R4/R5/R6 fl_valid", {31'h0, fl_valid}, {31'h0, m_valid});
        check("R7 trig_ind", {31'h0, trig_ind}, {31'h0, m_ti});
        check("R8/R9 stop_req", {31'h0, stop_req}, {31'h0, m_pend});
        check("R8/R12 stopped", {31'h0, stopped}, {31'h0, m_stopped});
        check("R10 mark_req", {31'h0, mark_req}, {31'h0, m_mk});
        check("R11 mode", {30'h0, fmt_cont, fmt_en}, {30'h0, m_ctrl[1:0]});
    endtask

    // one clock: drive at negedge, step model, compare after the edge
    task automatic cyc(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic t, input logic f, input logic h, input logic z,
                       input logic r, input logic dd);
        logic tr, fr, evt, done, wok, req;
        logic [15:0] nc;
        logic np, ns;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        trig_in = t; flush_in = f; tc_hit = h; tc_reload_zero = z;
        fl_ready = r; drain_done = dd;
        tr   = t & ~m_tq;
        fr   = f & ~m_fq;
        evt  = h | (z & tr);
        done = m_valid & r;
        wok  = wr && (a == 12'h304);
        nc = m_ctrl;
        if (wok) begin
            nc = d[15:0] & 16'hB773;
            nc[6] = m_ctrl[6] | d[6];
            if (!m_stopped) nc[1:0] = m_ctrl[1:0];
        end
        if (done) nc[6] = 1'b0;
        req = (wok & d[6]) | (m_ctrl[5] & evt) | (m_ctrl[4] & fr);
        np = m_pend; ns = m_stopped;
        if (m_pend && dd) begin
            np = 1'b0; ns = 1'b1;
        end else if (!m_stopped && ((m_ctrl[12] & done) | (m_ctrl[13] & evt))) begin
            np = 1'b1;
        end else if (m_stopped && !m_pend && wok && (d[0] | d[1])) begin
            ns = 1'b0;
        end
        @(negedge clk);
        m_ti = (m_ctrl[8] & tr) | (m_ctrl[9] & evt) | (m_ctrl[10] & done);
        m_mk = done & m_ctrl[15] & (m_ctrl[0] | m_ctrl[1]);
        m_valid = m_valid ? ~r : req;
        m_ctrl = nc; m_pend = np; m_stopped = ns; m_tq = t; m_fq = f;
        compare_all();
    endtask

    task automatic wr_ctrl(input logic [31:0] d);
        cyc(1'b1, 12'h304, d, trig_in, flush_in, 1'b0, tc_reload_zero, 1'b0, 1'b0);
    endtask

    task automatic idle(input logic r, input logic dd);
        cyc(1'b0, 12'h304, 32'h0, trig_in, flush_in, 1'b0, tc_reload_zero, r, dd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_ctrl = 16'h1000; m_valid = 0; m_pend = 0; m_stopped = 1;
        m_ti = 0; m_mk = 0; m_tq = 0; m_fq = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset rdata", reg_rdata, 32'h0000_1000);
        check("R1 reset stopped", {31'h0, stopped}, 32'h1);
        check("R1 reset outputs", {28'h0, fl_valid, trig_ind, mark_req, stop_req}, 32'h0);
        check("R10 marker id", {16'h0, mark_id, mark_byte}, 32'h0000_7B00);
        reg_addr = 12'h300;
        #1 check("R1 other address", reg_rdata, 32'h0);

        // R2 R11 R12: all ones while stopped; bit 6 starts a flush (R3)
        wr_ctrl(32'hFFFF_FFFF);
        check("R2 reserved zero", reg_rdata, 32'h0000_B773);
        check("R12 running", {31'h0, stopped}, 32'h0);
        check("R3 manual flush", {31'h0, fl_valid}, 32'h1);
        // R6 hold without ready; flush pin edge merges
        cyc(1'b0, 12'h304, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R6 hold", {31'h0, fl_valid}, 32'h1);
        // completion with a same-cycle manual write: R3 R6 R7 R8 R10
        cyc(1'b1, 12'h304, 32'h0000_B770, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R6 dropped after done", {31'h0, fl_valid}, 32'h0);
        check("R3 man cleared", reg_rdata & 32'h40, 32'h0);
        check("R11 locked", {30'h0, fmt_cont, fmt_en}, 32'h3);
        check("R7 pulse", {31'h0, trig_ind}, 32'h1);
        check("R10 marker", {31'h0, mark_req}, 32'h1);
        check("R8 stop_req", {31'h0, stop_req}, 32'h1);
        idle(1'b0, 1'b0);
        check("R7 single pulse", {31'h0, trig_ind}, 32'h0);
        idle(1'b0, 1'b1);
        check("R8 stopped", {31'h0, stopped}, 32'h1);
        // bypass: bit 15 ignored (R10); trigger pin with zero reload (R5)
        wr_ctrl(32'h0000_8020);
        check("R12 stays stopped", {31'h0, stopped}, 32'h1);
        cyc(1'b0, 12'h304, 0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R5 trigger flush", {31'h0, fl_valid}, 32'h1);
        idle(1'b1, 1'b0);
        check("R10 bypass no marker", {31'h0, mark_req}, 32'h0);
        // R4 flush pin disabled
        cyc(1'b0, 12'h304, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 12'h304, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        idle(1'b0, 1'b0);
        check("R4 pin disabled", {31'h0, fl_valid}, 32'h0);
        // R9 stop on trigger
        wr_ctrl(32'h0000_2001);
        cyc(1'b0, 12'h304, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R9 stop on trigger", {31'h0, stop_req}, 32'h1);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            logic wr;
            logic [11:0] a;
            logic [31:0] d;
            wr = ($urandom_range(0, 9) == 0);
            a  = ($urandom_range(0, 7) == 0) ? 12'h308 : 12'h304;
            d  = $urandom();
            cyc(wr, a, d,
                ($urandom_range(0, 3) == 0) ? ~trig_in : trig_in,
                ($urandom_range(0, 3) == 0) ? ~flush_in : flush_in,
                ($urandom_range(0, 15) == 0),
                $urandom_range(0, 1) == 1,
                ($urandom_range(0, 2) == 0),
                ($urandom_range(0, 2) == 0));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule